// File: doc/BRIEF.md
# Macro Instruction Sequencer Core

This core runs short macro programs for a command processor. After a start strobe it clears its register file, takes the first word from the parameter FIFO into register 1, and then fetches 32-bit instructions from a local instruction memory. It keeps executing them until an exit instruction and that instruction's delay slot have completed. Conditional branches test source register A for zero or non-zero and have one delay slot. A taken branch can annul that slot.

Each non-branch instruction is handed to an external execution unit through a one-cycle strobe. The strobe carries the instruction word, its address and both source register values. The core then waits for that unit's result and writes it into the destination register. The core only does sequencing, register storage and branch resolution. The arithmetic and the result dispatch sit in the neighbouring blocks. A branch found in any delay slot, or an undefined operation code, stops the core and raises the error flag.

Top module: `macro_seq_core`

## Requirements
- R1: After reset, busy, done, err, imem_en, prm_pop and ex_valid are all low. They stay low while the core is idle, and start is ignored while busy.
- R2: On start, every register is cleared. The core then waits for prm_valid, pops exactly one word, and places it in register 1 before the first fetch.
- R3: The program counter is a byte address that starts at 0 and normally advances by 4. imem_addr is the program counter divided by 4. Each fetch holds imem_en for one cycle and is followed by one wait state, after which imem_rdata is taken.
- R4: Register 0 always reads as zero, and writes to it are discarded.
- R5: Instruction fields are op [2:0], exit [3], branch condition [4] (0 = branch if zero, 1 = branch if non-zero), annul [5], destination [10:8], source A [13:11], source B [16:14] and a signed immediate [31:14]. Op values: 0 ALU, 1 add-immediate, 2 to 5 other data operations, 6 branch, 7 undefined. A branch target is the branch's own address plus the immediate times 4.
- R6: A taken branch without annul executes the next sequential instruction as its delay slot, then continues at the target.
- R7: A taken branch with annul continues at the target directly, and the delay-slot instruction never executes. The exit bit of a taken branch is ignored.
- R8: An instruction with the exit bit set is followed by exactly one more instruction, and then the core halts. If the exit sits in a branch delay slot, that extra instruction is the one at the branch target.
- R9: A branch decoded in a delay slot of either kind halts the core with err set, and the branch is not executed.
- R10: Op value 7 halts the core with err set, and the instruction is not executed.
- R11: done pulses for one cycle as busy falls. err keeps its value until the next start.
- R12: Every non-branch instruction raises ex_valid for one cycle, with ex_pc, ex_instr, ex_a and ex_b. The core waits for res_valid, and then writes res_data to the destination when res_we is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a program run at address 0 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| err | output | 1 | The last run ended on an illegal instruction |
| imem_en | output | 1 | Instruction memory read enable |
| imem_addr | output | 8 | Instruction memory word address |
| imem_rdata | input | 32 | Instruction word, valid one cycle after imem_en |
| prm_valid | input | 1 | Parameter FIFO has a word |
| prm_data | input | 32 | Parameter FIFO head word |
| prm_pop | output | 1 | Take the head word from the parameter FIFO |
| ex_valid | output | 1 | Instruction issued to the execution unit |
| ex_pc | output | 10 | Byte address of the issued instruction |
| ex_instr | output | 32 | Issued instruction word |
| ex_a | output | 32 | Source A register value |
| ex_b | output | 32 | Source B register value |
| res_valid | input | 1 | Execution result is ready |
| res_we | input | 1 | Write the result to the destination register |
| res_data | input | 32 | Execution result |

## Verification
The exit delay slot and the branch delay slot can fall on the same instruction. An exit placed in the slot of a taken branch has to hand its own slot to the branch target, and nothing after the target may run. The bench provokes this with a branch whose slot carries the exit bit. It judges the run by the executed address trace, which must be the slot followed by the target, and by a clean done with err low. A branch placed in an exit slot, which should stop with err, covers the opposite collision.

// File: rtl/msc_pkg.sv
package msc_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned IMM_W   = 18;
   localparam int unsigned RIDX_W  = 3;

   typedef enum logic [2:0] {
      OP_ALU    = 3'd0,
      OP_ADDI   = 3'd1,
      OP_BFINS  = 3'd2,
      OP_BFSHI  = 3'd3,
      OP_BFSHR  = 3'd4,
      OP_READ   = 3'd5,
      OP_BRANCH = 3'd6,
      OP_BAD    = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_PARAM, S_FETCH, S_FWAIT, S_EXEC, S_WB
   } seq_state_e;

   typedef struct packed {
      op_e               op;
      logic              ext;
      logic              cond_nz;
      logic              annul;
      logic [RIDX_W-1:0] dst;
      logic [RIDX_W-1:0] sa;
      logic [RIDX_W-1:0] sb;
      logic [IMM_W-1:0]  imm;
   } dec_t;

endpackage

// File: rtl/msc_decode.sv
module msc_decode
   import msc_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);

   logic unused_pad;
   assign unused_pad = ^instr[7:6];

   always_comb begin
      dec.op      = op_e'(instr[2:0]);
      dec.ext     = instr[3];
      dec.cond_nz = instr[4];
      dec.annul   = instr[5];
      dec.dst     = instr[10:8];
      dec.sa      = instr[13:11];
      dec.sb      = instr[16:14];
      dec.imm     = instr[31:14];
   end

endmodule

// File: rtl/msc_regfile.sv
module msc_regfile #(
   parameter int unsigned NREGS = 8,
   parameter int unsigned DW    = 32,
   localparam int unsigned RIW  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           we,
   input  logic [RIW-1:0] waddr,
   input  logic [DW-1:0]  wdata,
   input  logic [RIW-1:0] ra0,
   input  logic [RIW-1:0] ra1,
   output logic [DW-1:0]  rd0,
   output logic [DW-1:0]  rd1
);

   logic [DW-1:0] q [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign q[i] = '0;
      end else begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= '0;
            else if (clr)
               q[i] <= '0;
            else if (we && waddr == RIW'(i))
               q[i] <= wdata;
         end
      end
   end

   assign rd0 = q[ra0];
   assign rd1 = q[ra1];

endmodule

// File: rtl/msc_branch.sv
module msc_branch
   import msc_pkg::*;
#(
   parameter int unsigned PC_W = 10,
   parameter int unsigned DW   = 32
) (
   input  logic [PC_W-1:0]  base,
   input  logic [IMM_W-1:0] imm,
   input  logic             cond_nz,
   input  logic [DW-1:0]    val,
   output logic             taken,
   output logic [PC_W-1:0]  target
);

   localparam int unsigned OFF_W = IMM_W + 2;

   if (PC_W > OFF_W) begin : g_chk
      $error("msc_branch: PC_W wider than the branch offset");
   end

   logic [OFF_W-1:0] off;
   logic             is_zero;
   logic             unused_off;

   assign off        = {imm, 2'b00};
   assign unused_off = ^off[OFF_W-1:PC_W];
   assign is_zero    = (val == '0);
   assign taken      = cond_nz ? !is_zero : is_zero;
   assign target     = base + off[PC_W-1:0];

endmodule

// File: rtl/macro_seq_core.sv
module macro_seq_core
   import msc_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned NREGS      = 8,
   parameter int unsigned IMEM_DEPTH = 256,
   localparam int unsigned AW        = $clog2(IMEM_DEPTH),
   localparam int unsigned PC_W      = AW + 2,
   localparam int unsigned RIW       = $clog2(NREGS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic               imem_en,
   output logic [AW-1:0]      imem_addr,
   input  logic [INSTR_W-1:0] imem_rdata,
   input  logic               prm_valid,
   input  logic [DW-1:0]      prm_data,
   output logic               prm_pop,
   output logic               ex_valid,
   output logic [PC_W-1:0]    ex_pc,
   output logic [INSTR_W-1:0] ex_instr,
   output logic [DW-1:0]      ex_a,
   output logic [DW-1:0]      ex_b,
   input  logic               res_valid,
   input  logic               res_we,
   input  logic [DW-1:0]      res_data
);

   if (NREGS < 2 || NREGS > (1 << RIDX_W) || (1 << RIW) != NREGS) begin : g_chk_regs
      $error("macro_seq_core: NREGS must be a power of two from 2 to 8");
   end
   if ((1 << AW) != IMEM_DEPTH) begin : g_chk_depth
      $error("macro_seq_core: IMEM_DEPTH must be a power of two");
   end
   if (DW < 2) begin : g_chk_dw
      $error("macro_seq_core: DW too small");
   end

   seq_state_e       state_q;
   logic [PC_W-1:0]  pc_q, tgt_q;
   logic             tgt_pend_q, slot_q, exit_pend_q, done_q, err_q;
   logic [INSTR_W-1:0] ir_q;

   dec_t             dec;
   logic [DW-1:0]    rd0, rd1;
   logic             br_taken;
   logic [PC_W-1:0]  br_target, seq_pc;
   logic             is_branch, is_bad, illegal, advance;
   logic             rf_clr, rf_we;
   logic [RIW-1:0]   rf_waddr;
   logic [DW-1:0]    rf_wdata;
   logic             unused_idx;

   msc_decode u_dec (
      .instr (ir_q),
      .dec   (dec)
   );

   msc_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rf_clr),
      .we    (rf_we),
      .waddr (rf_waddr),
      .wdata (rf_wdata),
      .ra0   (dec.sa[RIW-1:0]),
      .ra1   (dec.sb[RIW-1:0]),
      .rd0   (rd0),
      .rd1   (rd1)
   );

   msc_branch #(.PC_W(PC_W), .DW(DW)) u_br (
      .base    (pc_q),
      .imm     (dec.imm),
      .cond_nz (dec.cond_nz),
      .val     (rd0),
      .taken   (br_taken),
      .target  (br_target)
   );

   assign unused_idx = ^{dec.sa, dec.sb, dec.dst};

   assign is_branch = (dec.op == OP_BRANCH);
   assign is_bad    = (dec.op == OP_BAD);
   assign illegal   = is_bad || (is_branch && slot_q);
   assign seq_pc    = tgt_pend_q ? tgt_q : pc_q + PC_W'(4);
   assign advance   = (state_q == S_EXEC && is_branch && !slot_q && !br_taken)
                   || (state_q == S_WB && res_valid);

   assign rf_clr   = (state_q == S_IDLE) && start;
   assign rf_we    = (state_q == S_PARAM && prm_valid)
                  || (state_q == S_WB && res_valid && res_we);
   assign rf_waddr = (state_q == S_PARAM) ? RIW'(1) : dec.dst[RIW-1:0];
   assign rf_wdata = (state_q == S_PARAM) ? prm_data : res_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         pc_q        <= '0;
         tgt_q       <= '0;
         tgt_pend_q  <= 1'b0;
         slot_q      <= 1'b0;
         exit_pend_q <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         ir_q        <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (start) begin
                  state_q     <= S_PARAM;
                  pc_q        <= '0;
                  tgt_pend_q  <= 1'b0;
                  slot_q      <= 1'b0;
                  exit_pend_q <= 1'b0;
                  err_q       <= 1'b0;
               end
            end
            S_PARAM: begin
               if (prm_valid) state_q <= S_FETCH;
            end
            S_FETCH: state_q <= S_FWAIT;
            S_FWAIT: begin
               ir_q    <= imem_rdata;
               state_q <= S_EXEC;
            end
            S_EXEC: begin
               if (illegal) begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
                  err_q   <= 1'b1;
               end else if (is_branch) begin
                  if (br_taken && dec.annul) begin
                     pc_q    <= br_target;
                     slot_q  <= 1'b0;
                     state_q <= S_FETCH;
                  end else if (br_taken) begin
                     tgt_q      <= br_target;
                     tgt_pend_q <= 1'b1;
                     pc_q       <= pc_q + PC_W'(4);
                     slot_q     <= 1'b1;
                     state_q    <= S_FETCH;
                  end
               end else begin
                  state_q <= S_WB;
               end
            end
            S_WB: ;
            default: state_q <= S_IDLE;
         endcase

         if (advance) begin
            if (exit_pend_q) begin
               state_q <= S_IDLE;
               done_q  <= 1'b1;
            end else begin
               pc_q        <= seq_pc;
               tgt_pend_q  <= 1'b0;
               slot_q      <= dec.ext;
               exit_pend_q <= dec.ext;
               state_q     <= S_FETCH;
            end
         end
      end
   end

   assign busy      = (state_q != S_IDLE);
   assign done      = done_q;
   assign err       = err_q;
   assign imem_en   = (state_q == S_FETCH);
   assign imem_addr = pc_q[PC_W-1:2];
   assign prm_pop   = (state_q == S_PARAM) && prm_valid;
   assign ex_valid  = (state_q == S_EXEC) && !is_branch && !is_bad;
   assign ex_pc     = pc_q;
   assign ex_instr  = ir_q;
   assign ex_a      = rd0;
   assign ex_b      = rd1;

endmodule

// File: rtl/macro_seq_core_checker.sv
module macro_seq_core_checker #(
   parameter int unsigned DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic          imem_en,
   input logic          prm_valid,
   input logic          prm_pop,
   input logic          ex_valid,
   input logic [31:0]   ex_instr,
   input logic [DW-1:0] ex_a
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!imem_en && !ex_valid && !prm_pop));

   a_r2_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      prm_pop |-> (prm_valid && busy));

   a_r3_fetch_wait: assert property (@(posedge clk) disable iff (!rst_n)
      imem_en |=> !imem_en);

   a_r4_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_instr[13:11] == 3'd0) |-> (ex_a == '0));

   a_r11_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_err_at_halt: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

   a_r12_issue_single: assert property (@(posedge clk) disable iff (!rst_n)
      ex_valid |=> !ex_valid);

endmodule

bind macro_seq_core macro_seq_core_checker #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .imem_en   (imem_en),
   .prm_valid (prm_valid),
   .prm_pop   (prm_pop),
   .ex_valid  (ex_valid),
   .ex_instr  (ex_instr),
   .ex_a      (ex_a)
);

// File: tb/macro_seq_core_bench.sv
module macro_seq_core_bench;

   localparam int CLK_PERIOD = 10;
   localparam int RUN_LIMIT  = 5000;
   // columns: first parameter, expected final ex_a, expected issue count
   localparam logic [31:0] VEC [3][3] = '{
      '{32'd1, 32'd4,  32'd5},
      '{32'd2, 32'd8,  32'd8},
      '{32'd5, 32'd20, 32'd17}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done, err, imem_en, prm_pop, ex_valid;
   logic [7:0]  imem_addr;
   logic [31:0] imem_rdata = '0;
   logic        prm_valid = 1'b0;
   logic [31:0] prm_data = '0;
   logic [9:0]  ex_pc;
   logic [31:0] ex_instr, ex_a, ex_b;
   logic        res_valid = 1'b0;
   logic        res_we = 1'b1;
   logic [31:0] res_data = '0;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] mem [256];
   logic [9:0]  tr_pc [64];
   logic [31:0] tr_a  [64];
   logic [31:0] tr_b  [64];
   int          tr_n = 0;
   int          base = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   macro_seq_core u_macro_seq_core (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
      .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .prm_valid(prm_valid), .prm_data(prm_data), .prm_pop(prm_pop),
      .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr), .ex_a(ex_a), .ex_b(ex_b),
      .res_valid(res_valid), .res_we(res_we), .res_data(res_data)
   );

   // synchronous instruction memory model
   always @(posedge clk) if (imem_en) imem_rdata <= mem[imem_addr];

   // execution unit model: add-immediate for op 1, register add otherwise
   always @(posedge clk) begin
      res_valid <= ex_valid;
      res_data  <= (ex_instr[2:0] == 3'd1)
                   ? ex_a + {{14{ex_instr[31]}}, ex_instr[31:14]} : ex_a + ex_b;
   end

   always @(posedge clk) if (ex_valid) begin
      tr_pc[tr_n % 64] <= ex_pc;
      tr_a[tr_n % 64]  <= ex_a;
      tr_b[tr_n % 64]  <= ex_b;
      tr_n <= tr_n + 1;
   end

   function automatic logic [31:0] f_i(input logic [2:0] op, input logic ext,
                                       input logic [2:0] dst, input logic [2:0] sa,
                                       input int imm);
      logic [17:0] im = imm[17:0];
      return {im, sa, dst, 2'b00, 2'b00, ext, op};
   endfunction

   function automatic logic [31:0] f_r(input logic ext, input logic [2:0] dst,
                                       input logic [2:0] sa, input logic [2:0] sb);
      return {15'd0, sb, sa, dst, 2'b00, 2'b00, ext, 3'd0};
   endfunction

   function automatic logic [31:0] f_br(input logic nz, input logic annul,
                                        input logic [2:0] sa, input int imm);
      logic [17:0] im = imm[17:0];
      return {im, sa, 3'd0, 2'b00, annul, nz, 1'b0, 3'd6};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 32'h7;
   endtask

   task automatic run(input logic [31:0] p);
      int cyc = 0;
      @(negedge clk);
      base      = tr_n;
      prm_data  = p;
      prm_valid = 1'b1;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!prm_pop && cyc < RUN_LIMIT) begin @(negedge clk); cyc++; end
      @(negedge clk);
      prm_valid = 1'b0;
      while (!done && cyc < RUN_LIMIT) begin @(negedge clk); cyc++; end
      if (cyc >= RUN_LIMIT) check("run timeout", 32'd0, 32'd1);
   endtask

   function automatic int cnt();
      return tr_n - base;
   endfunction

   task automatic load_loop();
      clear_mem();
      mem[0] = f_i(3'd1, 1'b0, 3'd2, 3'd2, 3);
      mem[1] = f_i(3'd1, 1'b0, 3'd1, 3'd1, -1);
      mem[2] = f_br(1'b1, 1'b0, 3'd1, -2);
      mem[3] = f_i(3'd1, 1'b0, 3'd3, 3'd3, 1);
      mem[4] = f_r(1'b1, 3'd4, 3'd2, 3'd3);
      mem[5] = f_i(3'd1, 1'b0, 3'd5, 3'd4, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 done/err", {30'd0, done, err}, 32'd0);
      check("R1 strobes", {29'd0, imem_en, prm_pop, ex_valid}, 32'd0);

      // table walk: countdown loop, R6 delay slot on taken branch, R5 conditions
      for (int i = 0; i < 3; i++) begin
         load_loop();
         run(VEC[i][0]);
         check("R6 loop err", {31'd0, err}, 32'd0);
         check("R6 loop issue count", cnt(), VEC[i][2]);
         check("R3 first pc", {22'd0, tr_pc[base % 64]}, 32'd0);
         check("R8 last pc", {22'd0, tr_pc[(tr_n - 1) % 64]}, 32'd20);
         check("R5 final value", tr_a[(tr_n - 1) % 64], VEC[i][1]);
         check("R11 busy low", {31'd0, busy}, 32'd0);
      end

      // R7 annul: slot skipped
      clear_mem();
      mem[0] = f_br(1'b0, 1'b1, 3'd0, 3);
      mem[1] = f_i(3'd1, 1'b0, 3'd2, 3'd0, 1);
      mem[3] = f_i(3'd1, 1'b1, 3'd6, 3'd0, 7);
      mem[4] = f_i(3'd1, 1'b0, 3'd7, 3'd6, 0);
      mem[5] = f_i(3'd1, 1'b0, 3'd2, 3'd0, 1);
      run(32'd9);
      check("R7 count", cnt(), 32'd2);
      check("R7 target pc", {22'd0, tr_pc[base % 64]}, 32'd12);
      check("R8 exit slot pc", {22'd0, tr_pc[(base + 1) % 64]}, 32'd16);
      check("R12 result written", tr_a[(base + 1) % 64], 32'd7);

      // R8 exit inside branch delay slot: target becomes the exit slot
      clear_mem();
      mem[0] = f_br(1'b0, 1'b0, 3'd0, 4);
      mem[1] = f_i(3'd1, 1'b1, 3'd2, 3'd0, 1);
      mem[2] = f_i(3'd1, 1'b0, 3'd2, 3'd0, 1);
      mem[4] = f_i(3'd1, 1'b0, 3'd3, 3'd0, 5);
      mem[5] = f_i(3'd1, 1'b0, 3'd3, 3'd0, 5);
      run(32'd1);
      check("R8 err", {31'd0, err}, 32'd0);
      check("R8 count", cnt(), 32'd2);
      check("R8 slot pc", {22'd0, tr_pc[base % 64]}, 32'd4);
      check("R8 target pc", {22'd0, tr_pc[(base + 1) % 64]}, 32'd16);

      // R9 branch in branch slot
      clear_mem();
      mem[0] = f_br(1'b0, 1'b0, 3'd0, 4);
      mem[1] = f_br(1'b0, 1'b0, 3'd0, -1);
      run(32'd1);
      check("R9 branch slot err", {31'd0, err}, 32'd1);
      check("R9 branch slot count", cnt(), 32'd0);

      // R9 branch in exit slot
      clear_mem();
      mem[0] = f_i(3'd1, 1'b1, 3'd2, 3'd0, 1);
      mem[1] = f_br(1'b0, 1'b0, 3'd0, 4);
      run(32'd1);
      check("R9 exit slot err", {31'd0, err}, 32'd1);
      check("R9 exit slot count", cnt(), 32'd1);

      // R10 undefined op
      clear_mem();
      mem[0] = f_i(3'd1, 1'b0, 3'd2, 3'd0, 1);
      run(32'd1);
      check("R10 err", {31'd0, err}, 32'd1);
      check("R10 count", cnt(), 32'd1);
      repeat (3) @(negedge clk);
      check("R11 err held", {31'd0, err}, 32'd1);

      // R2/R4: param to r1, r0 write discarded, registers cleared, err cleared
      clear_mem();
      mem[0] = f_i(3'd1, 1'b0, 3'd0, 3'd0, 9);
      mem[1] = f_r(1'b1, 3'd1, 3'd0, 3'd1);
      mem[2] = f_i(3'd1, 1'b0, 3'd3, 3'd2, 0);
      run(32'h1234);
      check("R11 err cleared", {31'd0, err}, 32'd0);
      check("R2 count", cnt(), 32'd3);
      check("R4 r0 zero", tr_a[(base + 1) % 64], 32'd0);
      check("R2 r1 param", tr_b[(base + 1) % 64], 32'h1234);
      check("R2 regs cleared", tr_a[(base + 2) % 64], 32'd0);
      check("R3 sequential pc", {22'd0, tr_pc[(base + 2) % 64]}, 32'd8);

      // R1 start ignored while busy is not exercised directly; idle after run
      check("R1 idle after run", {29'd0, imem_en, prm_pop, ex_valid}, 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule